// File: doc/BRIEF.md
# Serial Port Interrupt Controller

This block produces the interrupt requests of a synchronous serial port whose transmit and receive FIFOs each hold 8 words. It watches the two FIFO occupancy counts, a pulse for each frame the receiver completes and a pulse for each receive-FIFO read. From these it derives four conditions:

- a receive overrun;
- a receive idle timeout;
- a receive-level request;
- a transmit-level request.

Each condition goes through an enable mask. The masked conditions are then merged into one interrupt line.

The overrun and timeout conditions are sticky flags. Software removes them by writing ones to a clear register. The two level requests have no stored state: they follow the FIFO counts. The idle timeout runs for 32 serial bit periods. One bit period is the product of the prescaler setting and the serial-clock-rate setting plus one, counted in system clock cycles. The same period applies in master and slave mode.

Status bit order in `raw_status`, `masked_status`, the mask register and the clear register: bit 0 overrun, bit 1 timeout, bit 2 receive level, bit 3 transmit level. Register writes use `wr_sel`: 0 selects the mask register and 1 selects the clear register.

Top module: `sport_irq_ctrl`

## Requirements
- R1: A `rx_frame_done` pulse in a cycle where `rx_level` equals 8 sets raw bit 0 after that clock edge. A pulse at any lower level leaves bit 0 unchanged.
- R2: Raw bit 0 stays set until a clear write (`wr_en`=1, `wr_sel`=1) has `wr_data` bit 0 at 1. Zero bits in a clear write have no effect. When a set and a clear occur in the same cycle, the set wins.
- R3: While `rx_level` is non-zero and no `rx_pop` occurs, raw bit 1 becomes 1 after the 32·P-th clock edge. Here P = `prescale`·(`rate`+1), and a product of 0 counts as 1.
- R4: The timeout count restarts from zero in every cycle with `rx_pop`=1 and in every cycle with `rx_level`=0. An empty receive FIFO never raises bit 1.
- R5: Raw bit 1 stays set after receive-FIFO reads. A clear write with `wr_data` bit 1 at 1 removes it, and a set in the same cycle wins.
- R6: Raw bit 2 is 1 exactly when `rx_level` is 4 or more. It follows the input in the same cycle.
- R7: Raw bit 3 is 1 exactly when `tx_level` is 4 or less. It follows the input in the same cycle.
- R8: `masked_status` equals `raw_status` AND the mask register. A mask write (`wr_en`=1, `wr_sel`=0) loads `wr_data`, which takes effect after the edge. The mask resets to 0, so `masked_status` is 0 after reset.
- R9: `irq` is a register. After each edge it shows the OR of the `masked_status` bits from the cycle before, and it is 0 in reset.
- R10: Bits 2 and 3 have no clear bit. A clear write with ones in `wr_data` bits 3:2 leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_level | input | 4 | Entries held in the transmit FIFO (0..8) |
| rx_level | input | 4 | Entries held in the receive FIFO (0..8) |
| rx_frame_done | input | 1 | One-cycle pulse per completed incoming frame |
| rx_pop | input | 1 | One-cycle pulse per receive-FIFO read |
| prescale | input | 8 | Prescaler setting |
| rate | input | 8 | Serial-clock-rate setting |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the mask register, 1 selects the clear register |
| wr_data | input | 4 | Write data, one bit per condition |
| raw_status | output | 4 | Unmasked conditions |
| masked_status | output | 4 | Conditions ANDed with the mask |
| irq | output | 1 | Registered combined interrupt |

## Verification
The properties take for granted that both level inputs stay within 0 to 8. They also assume that `rx_frame_done` and `rx_pop` are single-cycle events sampled on the same clock, and that the prescaler and rate settings are steady while a timeout window runs. The bench changes every input shortly after a rising edge, and only to FIFO counts that an 8-entry FIFO can hold. It changes the prescaler and rate only while the receive count is zero or during a read, so the timeout window always starts from a known restart cycle.

// File: rtl/sport_irq_pkg.sv
package sport_irq_pkg;
  localparam int unsigned ST_W    = 4;
  localparam int unsigned IDX_OVR = 0;
  localparam int unsigned IDX_TMO = 1;
  localparam int unsigned IDX_RXL = 2;
  localparam int unsigned IDX_TXL = 3;

  typedef enum logic {
    SEL_MASK  = 1'b0,
    SEL_CLEAR = 1'b1
  } wr_sel_e;
endpackage

// File: rtl/sport_tmo_timer.sv
module sport_tmo_timer #(
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned RATE_W = 8,
  parameter int unsigned BITS   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [PRE_W-1:0]  prescale,
  input  logic [RATE_W-1:0] rate,
  output logic              expire
);
  localparam int unsigned PER_W = PRE_W + RATE_W + 1;
  localparam int unsigned BIT_W = $clog2(BITS + 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BITS - 1);
  localparam logic [BIT_W-1:0] BIT_DONE = BIT_W'(BITS);

  logic [PER_W-1:0] per_c, per_lim;
  logic [PER_W-1:0] pcnt_q, pcnt_d;
  logic [BIT_W-1:0] bcnt_q, bcnt_d;
  logic             tick, done, cnt_en;

  always_comb begin
    per_c   = PER_W'(prescale) * (PER_W'(rate) + PER_W'(1));
    per_lim = (per_c == '0) ? '0 : per_c - PER_W'(1);
    tick    = (pcnt_q >= per_lim);
    done    = (bcnt_q == BIT_DONE);
    cnt_en  = restart | ~done;
    expire  = ~restart & ~done & tick & (bcnt_q == BIT_LAST);
  end

  always_comb begin
    pcnt_d = pcnt_q;
    bcnt_d = bcnt_q;
    if (restart) begin
      pcnt_d = '0;
      bcnt_d = '0;
    end else if (tick) begin
      pcnt_d = '0;
      bcnt_d = bcnt_q + BIT_W'(1);
    end else begin
      pcnt_d = pcnt_q + PER_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      bcnt_q <= '0;
    end else if (cnt_en) begin
      pcnt_q <= pcnt_d;
      bcnt_q <= bcnt_d;
    end
  end
endmodule

// File: rtl/sport_sticky_flag.sv
module sport_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_d, upd;

  always_comb begin
    upd = set | clr;
    q_d = set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (upd) q <= q_d;
  end
endmodule

// File: rtl/sport_level_cmp.sv
module sport_level_cmp #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] tx_level,
  input  logic [CNT_W-1:0] rx_level,
  output logic             rx_half,
  output logic             tx_half
);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(DEPTH / 2);

  always_comb begin
    rx_half = (rx_level >= HALF);
    tx_half = (tx_level <= HALF);
  end
endmodule

// File: rtl/sport_irq_ctrl.sv
module sport_irq_ctrl
  import sport_irq_pkg::*;
#(
  parameter int unsigned DEPTH    = 8,
  parameter int unsigned CNT_W    = $clog2(DEPTH + 1),
  parameter int unsigned PRE_W    = 8,
  parameter int unsigned RATE_W   = 8,
  parameter int unsigned TMO_BITS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  tx_level,
  input  logic [CNT_W-1:0]  rx_level,
  input  logic              rx_frame_done,
  input  logic              rx_pop,
  input  logic [PRE_W-1:0]  prescale,
  input  logic [RATE_W-1:0] rate,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [ST_W-1:0]   wr_data,
  output logic [ST_W-1:0]   raw_status,
  output logic [ST_W-1:0]   masked_status,
  output logic              irq
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [ST_W-1:0] mask_q;
  logic            mask_we, clr_we;
  logic            tmo_restart, tmo_expire, ovr_set;
  logic [1:0]      flag_set, flag_clr, flag_q;
  logic            rx_half, tx_half, irq_d;

  always_comb begin
    mask_we     = wr_en & (wr_sel == SEL_MASK);
    clr_we      = wr_en & (wr_sel == SEL_CLEAR);
    tmo_restart = rx_pop | (rx_level == '0);
    ovr_set     = rx_frame_done & (rx_level == FULL);
    flag_set    = {tmo_expire, ovr_set};
    flag_clr    = {clr_we & wr_data[IDX_TMO], clr_we & wr_data[IDX_OVR]};
  end

  sport_tmo_timer #(
    .PRE_W (PRE_W),
    .RATE_W(RATE_W),
    .BITS  (TMO_BITS)
  ) i_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (tmo_restart),
    .prescale(prescale),
    .rate    (rate),
    .expire  (tmo_expire)
  );

  for (genvar g = 0; g < 2; g++) begin : g_flag
    sport_sticky_flag i_flag (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (flag_set[g]),
      .clr  (flag_clr[g]),
      .q    (flag_q[g])
    );
  end

  sport_level_cmp #(
    .DEPTH(DEPTH),
    .CNT_W(CNT_W)
  ) i_lvl (
    .tx_level(tx_level),
    .rx_level(rx_level),
    .rx_half (rx_half),
    .tx_half (tx_half)
  );

  always_comb begin
    raw_status          = '0;
    raw_status[IDX_OVR] = flag_q[0];
    raw_status[IDX_TMO] = flag_q[1];
    raw_status[IDX_RXL] = rx_half;
    raw_status[IDX_TXL] = tx_half;
    masked_status       = raw_status & mask_q;
    irq_d               = |masked_status;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end
endmodule

// File: rtl/sport_irq_chk.sv
module sport_irq_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] rx_level,
  input logic             rx_frame_done,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [3:0]       wr_data,
  input logic [3:0]       raw_status,
  input logic [3:0]       masked_status,
  input logic             irq
);
  logic ovr_ev, ovr_clr, tmo_clr;
  always_comb begin
    ovr_ev  = rx_frame_done && (rx_level == CNT_W'(DEPTH));
    ovr_clr = wr_en && wr_sel && wr_data[0];
    tmo_clr = wr_en && wr_sel && wr_data[1];
  end

  a_r1_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_ev |=> raw_status[0]);

  a_r1_overrun_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!raw_status[0] && !ovr_ev) |=> !raw_status[0]);

  a_r2_overrun_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_clr && !ovr_ev) |=> !raw_status[0]);

  a_r5_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_status[1] && !tmo_clr) |=> raw_status[1]);

  a_r4_timeout_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_status[1]) |-> ($past(rx_level) != '0));

  a_r8_masked_subset: assert property (@(posedge clk) disable iff (!rst_n)
    (masked_status & ~raw_status) == 4'b0000);

  a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (masked_status != 4'b0000) |=> irq);
endmodule

bind sport_irq_ctrl sport_irq_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_sport_irq_ctrl.sv
module test_sport_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] tx_level, rx_level, wr_data;
  logic       rx_frame_done, rx_pop, wr_en, wr_sel;
  logic [7:0] prescale, rate;
  logic [3:0] raw_status, masked_status;
  logic       irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sport_irq_ctrl i_sport_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
    .rx_frame_done(rx_frame_done), .rx_pop(rx_pop), .prescale(prescale),
    .rate(rate), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .raw_status(raw_status), .masked_status(masked_status), .irq(irq)
  );

  // {tx_level, rx_level, expected rx-level bit, expected tx-level bit}
  localparam logic [9:0] VEC [8] = '{
    {4'd1, 4'd0, 1'b0, 1'b1},
    {4'd4, 4'd0, 1'b0, 1'b1},
    {4'd5, 4'd0, 1'b0, 1'b0},
    {4'd8, 4'd3, 1'b0, 1'b0},
    {4'd8, 4'd4, 1'b1, 1'b0},
    {4'd6, 4'd8, 1'b1, 1'b0},
    {4'd0, 4'd5, 1'b1, 1'b1},
    {4'd7, 4'd2, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic sel, input logic [3:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    cyc(1);
    wr_en = 1'b0; wr_data = 4'h0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tx_level = 4'd0; rx_level = 4'd0; rx_frame_done = 1'b0;
    rx_pop = 1'b0; prescale = 8'd200; rate = 8'd255;
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = 4'h0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    #1;
    chk("R8 reset masked", 32'(masked_status), 32'h0);
    chk("R9 reset irq", 32'(irq), 32'h0);
    chk("R1 R5 reset sticky flags", 32'(raw_status[1:0]), 32'h0);

    wr(1'b0, 4'hF);
    for (int v = 0; v < 8; v++) begin
      tx_level = VEC[v][9:6];
      rx_level = VEC[v][5:2];
      #1;
      chk("R6 rx level bit", 32'(raw_status[2]), 32'(VEC[v][1]));
      chk("R7 tx level bit", 32'(raw_status[3]), 32'(VEC[v][0]));
      cyc(1);
      chk("R9 irq from levels", 32'(irq), 32'(VEC[v][1] | VEC[v][0]));
    end

    // timeout: P = 2*(1+1) = 4, window 128 cycles
    tx_level = 4'd8; rx_level = 4'd0;
    cyc(1);
    prescale = 8'd2; rate = 8'd1;
    cyc(1);
    rx_level = 4'd1;
    cyc(127);
    chk("R3 timeout not before 32P", 32'(raw_status[1]), 32'h0);
    cyc(1);
    chk("R3 timeout at 32P", 32'(raw_status[1]), 32'h1);

    rx_pop = 1'b1; wr_en = 1'b1; wr_sel = 1'b1; wr_data = 4'b0010;
    cyc(1);
    rx_pop = 1'b0; wr_en = 1'b0; wr_data = 4'h0;
    chk("R5 timeout cleared", 32'(raw_status[1]), 32'h0);
    cyc(100);
    rx_pop = 1'b1;
    cyc(1);
    rx_pop = 1'b0;
    cyc(127);
    chk("R4 pop restarts count", 32'(raw_status[1]), 32'h0);
    cyc(1);
    chk("R4 timeout after restart", 32'(raw_status[1]), 32'h1);
    rx_pop = 1'b1;
    cyc(1);
    rx_pop = 1'b0;
    chk("R5 timeout stays after read", 32'(raw_status[1]), 32'h1);

    rx_level = 4'd0;
    wr(1'b1, 4'b0010);
    cyc(200);
    chk("R4 empty fifo never times out", 32'(raw_status[1]), 32'h0);

    // overrun
    prescale = 8'd200; rate = 8'd255;
    rx_level = 4'd7; rx_frame_done = 1'b1;
    cyc(1);
    chk("R1 no overrun below full", 32'(raw_status[0]), 32'h0);
    rx_level = 4'd8;
    cyc(1);
    rx_frame_done = 1'b0;
    chk("R1 overrun when full", 32'(raw_status[0]), 32'h1);
    wr(1'b1, 4'b1110);
    chk("R2 zero bit leaves overrun", 32'(raw_status[0]), 32'h1);
    chk("R10 rx level not cleared", 32'(raw_status[2]), 32'h1);
    tx_level = 4'd2;
    wr(1'b1, 4'b1000);
    chk("R10 tx level not cleared", 32'(raw_status[3]), 32'h1);
    tx_level = 4'd8;
    wr(1'b1, 4'b0001);
    chk("R2 overrun cleared", 32'(raw_status[0]), 32'h0);
    rx_frame_done = 1'b1; wr_en = 1'b1; wr_sel = 1'b1; wr_data = 4'b0001;
    cyc(1);
    rx_frame_done = 1'b0; wr_en = 1'b0; wr_data = 4'h0;
    chk("R2 set wins over clear", 32'(raw_status[0]), 32'h1);

    // mask
    wr(1'b0, 4'b0001);
    #1;
    chk("R8 masked uses mask", 32'(masked_status), 32'h1);
    cyc(1);
    chk("R9 irq set", 32'(irq), 32'h1);
    wr(1'b1, 4'b0001);
    chk("R8 masked after clear", 32'(masked_status), 32'h0);
    chk("R9 irq lags one cycle", 32'(irq), 32'h1);
    cyc(1);
    chk("R9 irq dropped", 32'(irq), 32'h0);
    wr(1'b0, 4'b0000);
    #1;
    chk("R8 mask off hides rx level", 32'(masked_status), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule